// File: doc/BRIEF.md
# Dual-Clock Packet FIFO with Stall Handshake

This block moves fixed-width packets from one clock domain to another. A producer on the write clock raises a strobe together with a packet. While the storage has room, the packet is stored. The producer gets three signals back. The first is a threshold flag that it should treat as its stop signal. The second is a near-capacity warning. The third is a sticky error that records any write the storage could not accept.

On the read clock, packets come out of a registered output stage. That stage is paired with a valid strobe and follows a stall input. A consumer takes a packet on any read-clock edge where the strobe is high and the stall is low. While the stall is high, the output stage freezes and the read position stays where it is. Read and write positions cross between the domains as reflected-binary (gray) counters through two-flop synchronizers held inside the block. One active-low asynchronous reset clears both sides.

The read-side state machine has three states:
- `RD_IDLE`: strobe low, nothing held.
- `RD_LIVE`: a packet is on offer.
- `RD_HELD`: a packet is on offer and a stall has been seen.

Its transitions are:
- IDLE→LIVE on a load.
- LIVE→HELD and HELD→HELD while the stall is high.
- LIVE/HELD→LIVE when a packet is taken and another is loaded.
- LIVE/HELD→IDLE when a packet is taken and the storage is empty.
- IDLE→IDLE while the stall is high or no data is visible.

Top module: `pkt_cdc_fifo`

## Requirements
- R1: Every accepted packet leaves on the read side exactly once, unaltered, in write order.
- R2: A load happens on a read-clock edge where the synchronized write position differs from the read position and `rd_wait` is low. `rd_access` is high from the edge of the load onward, and it rises only after a cycle in which `rd_wait` was low.
- R3: If `rd_access` and `rd_wait` are both high at a read-clock edge, then after that edge `rd_access` is still high and `rd_packet` is unchanged.
- R4: While `rd_wait` is high and `rd_access` is low, no packet is loaded and `rd_access` stays low, even when data is stored.
- R5: `wr_prog_full` is registered on the write clock. It is high after an edge exactly when the stored count, taken after that edge's write against the synchronized read position, is at least `PROG_LVL` (default 12 of 16).
- R6: `wr_prog_full` does not block writes. Writes made while it is high are stored until true capacity, so a writer that stops on this flag never loses a packet.
- R7: `wr_almost_full` follows the same timing as R5, with threshold `ALMOST_LVL` (default 14).
- R8: A write while `DEPTH` packets are stored is dropped, stored packets are not overwritten, and `wr_overflow` goes high after that edge and stays high until reset.
- R9: Reset low clears `rd_access`, `rd_packet`, `wr_prog_full`, `wr_almost_full` and `wr_overflow` at once, even when the read clock is stopped.
- R10: Positions cross domains as gray codes one bit wider than the address, changing at most one bit per clock. Space freed by reads shows up in the write-side flags a few write-clock cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_access | input | 1 | Write strobe |
| wr_packet | input | W | Packet to store |
| wr_prog_full | output | 1 | Threshold flag; the writer's stop signal |
| wr_almost_full | output | 1 | Near-capacity warning |
| wr_overflow | output | 1 | Sticky dropped-write flag |
| rd_access | output | 1 | Packet on offer |
| rd_packet | output | W | Offered packet |
| rd_wait | input | 1 | Consumer stall |

## Verification
The faults that matter here show up at the ports, with different delays:
- A read position that advances during a stall shows up as a skipped or repeated packet at the next transfer. This is seen within a few read cycles.
- An output stage that does not freeze is caught on the very next read edge.
- A bad write position or flag threshold changes `wr_prog_full`, `wr_almost_full` or `wr_overflow` one write edge after the write that crosses the level.

These cases are compared exactly while the reader is stalled, because the synchronized read position cannot move then. Crossing faults show up as lost data or as flags that never clear once the reader has drained the storage.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_LIVE = 2'd1,
        RD_HELD = 2'd2
    } rd_state_t;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i + 1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/pcf_sync2.sv
module pcf_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            dout   <= '0;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end

endmodule

// File: rtl/pcf_wr_ctrl.sv
module pcf_wr_ctrl #(
    parameter int PTR_W      = 5,
    parameter int PROG_LVL   = 12,
    parameter int ALMOST_LVL = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_access,
    input  logic [PTR_W-1:0] rgray_sync,
    output logic             wr_en,
    output logic [PTR_W-2:0] waddr,
    output logic [PTR_W-1:0] wgray,
    output logic             full,
    output logic             prog_full,
    output logic             almost_full,
    output logic             overflow
);

    localparam logic [PTR_W-1:0] PROG_T   = PTR_W'(PROG_LVL);
    localparam logic [PTR_W-1:0] ALMOST_T = PTR_W'(ALMOST_LVL);

    logic [PTR_W-1:0] wbin;
    logic [PTR_W-1:0] wbin_nxt;
    logic [PTR_W-1:0] rbin_s;
    logic [PTR_W-1:0] fill_nxt;

    assign rbin_s   = PTR_W'(pcf_pkg::gray_to_bin(32'(rgray_sync)));
    assign full     = (wgray == {~rgray_sync[PTR_W-1:PTR_W-2],
                                 rgray_sync[PTR_W-3:0]});
    assign wr_en    = wr_access & ~full;
    assign wbin_nxt = wbin + PTR_W'(wr_en);
    assign fill_nxt = wbin_nxt - rbin_s;
    assign waddr    = wbin[PTR_W-2:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin        <= '0;
            wgray       <= '0;
            prog_full   <= 1'b0;
            almost_full <= 1'b0;
            overflow    <= 1'b0;
        end else begin
            wbin        <= wbin_nxt;
            wgray       <= PTR_W'(pcf_pkg::bin_to_gray(32'(wbin_nxt)));
            prog_full   <= (fill_nxt >= PROG_T);
            almost_full <= (fill_nxt >= ALMOST_T);
            overflow    <= overflow | (wr_access & full);
        end
    end

endmodule

// File: rtl/pcf_rd_ctrl.sv
module pcf_rd_ctrl #(
    parameter int PTR_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_wait,
    input  logic [PTR_W-1:0]    wgray_sync,
    output logic                load,
    output logic [PTR_W-2:0]    raddr,
    output logic [PTR_W-1:0]    rgray,
    output logic                rd_access,
    output pcf_pkg::rd_state_t  state
);

    import pcf_pkg::*;

    rd_state_t        state_nxt;
    logic [PTR_W-1:0] rbin;
    logic [PTR_W-1:0] rbin_nxt;
    logic             empty;

    assign empty    = (rgray == wgray_sync);
    assign load     = ~empty & ~rd_wait;
    assign rbin_nxt = rbin + PTR_W'(load);
    assign raddr    = rbin[PTR_W-2:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Read position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= PTR_W'(bin_to_gray(32'(rbin_nxt)));
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            RD_IDLE: begin
                if (load) state_nxt = RD_LIVE;
            end
            RD_LIVE, RD_HELD: begin
                if (rd_wait)   state_nxt = RD_HELD;
                else if (load) state_nxt = RD_LIVE;
                else           state_nxt = RD_IDLE;
            end
            default: state_nxt = RD_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rd_access = (state != RD_IDLE);
    end

endmodule

// File: rtl/pkt_cdc_fifo.sv
module pkt_cdc_fifo #(
    parameter int W          = 32,
    parameter int DEPTH      = 16,
    parameter int PROG_LVL   = 12,
    parameter int ALMOST_LVL = 14
) (
    input  logic         wr_clk,
    input  logic         rd_clk,
    input  logic         rst_n,
    input  logic         wr_access,
    input  logic [W-1:0] wr_packet,
    output logic         wr_prog_full,
    output logic         wr_almost_full,
    output logic         wr_overflow,
    output logic         rd_access,
    output logic [W-1:0] rd_packet,
    input  logic         rd_wait
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;

    logic [W-1:0]       mem [DEPTH];
    logic               wr_en;
    logic               wr_full;
    logic [ADDR_W-1:0]  waddr;
    logic [ADDR_W-1:0]  raddr;
    logic [PTR_W-1:0]   wgray;
    logic [PTR_W-1:0]   rgray;
    logic [PTR_W-1:0]   wgray_sync;
    logic [PTR_W-1:0]   rgray_sync;
    logic               rd_load;
    pcf_pkg::rd_state_t rd_state;

    pcf_wr_ctrl #(
        .PTR_W(PTR_W), .PROG_LVL(PROG_LVL), .ALMOST_LVL(ALMOST_LVL)
    ) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .wr_access(wr_access),
        .rgray_sync(rgray_sync), .wr_en(wr_en), .waddr(waddr),
        .wgray(wgray), .full(wr_full), .prog_full(wr_prog_full),
        .almost_full(wr_almost_full), .overflow(wr_overflow)
    );

    pcf_rd_ctrl #(.PTR_W(PTR_W)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .rd_wait(rd_wait),
        .wgray_sync(wgray_sync), .load(rd_load), .raddr(raddr),
        .rgray(rgray), .rd_access(rd_access), .state(rd_state)
    );

    pcf_sync2 #(.W(PTR_W)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .din(wgray), .dout(wgray_sync)
    );

    pcf_sync2 #(.W(PTR_W)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .din(rgray), .dout(rgray_sync)
    );

    always_ff @(posedge wr_clk) begin
        if (wr_en) mem[waddr] <= wr_packet;
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_packet <= '0;
        end else if (rd_load) begin
            rd_packet <= mem[raddr];
        end
    end

endmodule

// File: rtl/pkt_cdc_fifo_chk.sv
module pkt_cdc_fifo_chk #(
    parameter int W     = 32,
    parameter int PTR_W = 5
) (
    input logic             wclk,
    input logic             rclk,
    input logic             rst_n,
    input logic             wr_access,
    input logic             wr_full,
    input logic [PTR_W-1:0] wgray,
    input logic [PTR_W-1:0] rgray,
    input logic [PTR_W-1:0] rgray_sync,
    input logic             prog_full,
    input logic             almost_full,
    input logic             overflow,
    input logic             rd_access,
    input logic             rd_wait,
    input logic [W-1:0]     rd_packet
);

    // R3
    hold_on_wait_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_access && rd_wait) |=> (rd_access && $stable(rd_packet)));

    // R4
    idle_wait_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (!rd_access && rd_wait) |=> !rd_access);

    // R2
    access_rise_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        $rose(rd_access) |-> $past(!rd_wait));

    // R8
    overflow_sticky_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        overflow |=> overflow);

    // R8
    full_drop_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        wr_full |=> $stable(wgray));

    // R6
    prog_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (prog_full && wr_access && !wr_full) |=> !$stable(wgray));

    // R7
    almost_implies_prog_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        almost_full |-> prog_full);

    // R10
    wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R10
    rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

    // R10
    rsync_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(rgray_sync ^ $past(rgray_sync)) <= 1);

endmodule

bind pkt_cdc_fifo pkt_cdc_fifo_chk #(.W(W), .PTR_W(PTR_W)) u_chk (
    .wclk(wr_clk), .rclk(rd_clk), .rst_n(rst_n), .wr_access(wr_access),
    .wr_full(wr_full), .wgray(wgray), .rgray(rgray), .rgray_sync(rgray_sync),
    .prog_full(wr_prog_full), .almost_full(wr_almost_full),
    .overflow(wr_overflow), .rd_access(rd_access), .rd_wait(rd_wait),
    .rd_packet(rd_packet)
);

// File: tb/pkt_cdc_fifo_test.sv
`timescale 1ns/1ps
module pkt_cdc_fifo_test;

    localparam int W = 32;
    localparam int DEPTH = 16;
    localparam int PROG = 12;
    localparam int ALMOST = 14;

    logic         wr_clk = 1'b0;
    logic         rd_clk = 1'b0;
    logic         rd_clk_en = 1'b1;
    logic         rst_n = 1'b0;
    logic         wr_access = 1'b0;
    logic [W-1:0] wr_packet = '0;
    logic         wr_prog_full, wr_almost_full, wr_overflow;
    logic         rd_access;
    logic [W-1:0] rd_packet;
    logic         rd_wait = 1'b1;

    int           n_cmp = 0;
    int           n_bad = 0;
    int           wait_mode = 0;
    bit           held_pending = 0;
    logic [W-1:0] held_pkt;
    logic [W-1:0] exp_q[$];
    bit           finished = 0;

    pkt_cdc_fifo #(.W(W), .DEPTH(DEPTH), .PROG_LVL(PROG), .ALMOST_LVL(ALMOST)) uut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_access(wr_access), .wr_packet(wr_packet),
        .wr_prog_full(wr_prog_full), .wr_almost_full(wr_almost_full),
        .wr_overflow(wr_overflow), .rd_access(rd_access),
        .rd_packet(rd_packet), .rd_wait(rd_wait)
    );

    initial forever #2 wr_clk = ~wr_clk;
    initial forever begin
        #3.5;
        if (rd_clk_en) rd_clk = ~rd_clk;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Read-side reference: every clock, pick the stall value first, then judge the offer
    always @(negedge rd_clk) begin
        if (!rst_n) begin
            held_pending = 0;
        end else begin
            if (held_pending) begin
                // R3: frozen offer after a stalled edge
                chk(rd_access == 1'b1, "R3", "access held", rd_access, 1);
                chk(rd_packet == held_pkt, "R3", "packet held", rd_packet, held_pkt);
                held_pending = 0;
            end
            case (wait_mode)
                0: rd_wait = 1'b1;
                1: rd_wait = (($urandom % 3) == 0);
                2: rd_wait = 1'b0;
                default: rd_wait = rd_access;
            endcase
            if (rd_access && !rd_wait) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R1", "unexpected packet", rd_packet, 0);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    chk(rd_packet == e, "R1", "packet order", rd_packet, e);
                end
            end else if (rd_access && rd_wait) begin
                held_pending = 1;
                held_pkt = rd_packet;
            end
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            chk(0, "WATCHDOG", "run did not finish", 0, 1);
            finish_run();
        end
    end

    initial begin
        #22.5 rst_n = 1'b1;
        @(negedge wr_clk);
        // R9: values after reset
        chk(rd_access == 0, "R9", "reset access", rd_access, 0);
        chk(wr_prog_full == 0, "R9", "reset prog_full", wr_prog_full, 0);
        chk(wr_overflow == 0, "R9", "reset overflow", wr_overflow, 0);

        // Fill with the reader stalled: read position frozen, flags exact
        for (int a = 1; a <= DEPTH + 2; a++) begin
            @(negedge wr_clk);
            if (a > 1) begin
                int acc;
                acc = (a - 1 > DEPTH) ? DEPTH : a - 1;
                chk(wr_prog_full == (acc >= PROG), "R5", "prog_full level", wr_prog_full, acc >= PROG);
                chk(wr_almost_full == (acc >= ALMOST), "R7", "almost_full level", wr_almost_full, acc >= ALMOST);
                chk(wr_overflow == (a - 1 > DEPTH), "R8", "overflow flag", wr_overflow, a - 1 > DEPTH);
                chk(rd_access == 0, "R4", "no load while stalled", rd_access, 0);
            end
            if (a <= DEPTH + 1) begin
                wr_access = 1'b1;
                wr_packet = 32'hA500_0000 + a;
                if (a <= DEPTH) exp_q.push_back(wr_packet); // R6: stored past prog_full
            end else begin
                wr_access = 1'b0;
            end
        end

        // Drain with random stalls: order and the dropped write (R8, R6, R1)
        wait_mode = 1;
        for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge wr_clk);
        chk(exp_q.size() == 0, "R6", "all stored packets drained", exp_q.size(), 0);
        repeat (20) @(negedge wr_clk);
        chk(wr_overflow == 1, "R8", "overflow sticky", wr_overflow, 1);
        chk(wr_prog_full == 0, "R10", "prog_full cleared after drain", wr_prog_full, 0);
        chk(wr_almost_full == 0, "R10", "almost_full cleared after drain", wr_almost_full, 0);

        // Reset with both clocks running
        #0.3 rst_n = 1'b0;
        #3;
        chk(wr_overflow == 0, "R9", "overflow cleared", wr_overflow, 0);
        chk(rd_access == 0, "R9", "access cleared", rd_access, 0);
        exp_q.delete();
        #5.2 rst_n = 1'b1;

        // Streaming: writer obeys prog_full, reader stalls randomly
        for (int i = 0; i < 600; i++) begin
            @(negedge wr_clk);
            if (!wr_prog_full && ($urandom % 2 == 0)) begin
                wr_access = 1'b1;
                wr_packet = $urandom;
                exp_q.push_back(wr_packet);
            end else begin
                wr_access = 1'b0;
            end
        end
        @(negedge wr_clk) wr_access = 1'b0;
        wait_mode = 2;
        for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge wr_clk);
        chk(exp_q.size() == 0, "R1", "stream fully delivered", exp_q.size(), 0);
        chk(wr_overflow == 0, "R6", "no drop when obeying prog_full", wr_overflow, 0);

        // Offer a packet then stall it; stop the read clock; reset
        wait_mode = 3;
        @(negedge wr_clk);
        wr_access = 1'b1;
        wr_packet = 32'h0DD0_0001;
        exp_q.push_back(wr_packet);
        @(negedge wr_clk) wr_access = 1'b0;
        repeat (40) @(negedge wr_clk);
        chk(rd_access == 1, "R2", "access rises after data visible", rd_access, 1);
        chk(rd_packet == 32'h0DD0_0001, "R2", "offered packet", rd_packet, 32'h0DD0_0001);
        rd_clk_en = 1'b0;
        #20;
        rst_n = 1'b0;
        #1;
        chk(rd_access == 0, "R9", "access cleared without read clock", rd_access, 0);
        chk(rd_packet == 0, "R9", "packet cleared without read clock", rd_packet, 0);
        finished = 1;
        finish_run();
    end

endmodule